// File: doc/BRIEF.md
# I2C Master Write Controller

This block drives a two-wire serial bus as its only master and carries data in the write direction only. Software sets up a mode word, which holds the 7-bit target address, a master-on bit and a slave-off bit. It also sets a clock word, which holds the SCL low and high dividers and a shared prescale exponent. Writing a byte into the holding register then launches the transfer. The controller sends a start condition, then the address byte with a write bit, then every byte that software supplies. After each byte it checks the acknowledge.

When an acknowledged byte finishes and the holding register is empty, the controller closes the transfer with a stop condition on its own. A refused byte (NACK) also ends the transfer with a stop, and any byte still waiting is discarded. Three status outputs report the state: ready follows the holding register, complete follows the whole transfer, and nack follows the last acknowledge. Each of them can raise the interrupt output under its own enable bit. Both bus lines are open drain: an output-enable high pulls the line low. The SDA return path passes through a two-flop synchronizer.

Top module: `i2c_wr_master`

## Requirements
- R1: A write to the holding register (address 3, data bits [7:0]) while the master is idle and enabled starts the transfer with a start condition (SDA falls while SCL is high). Each transfer contains exactly one start.
- R2: The first byte on the bus is the target address from mode bits [6:0], followed by a 0 direction bit. Every byte is sent MSB first.
- R3: The data bytes appear on the bus in the order they were written. When a byte is acknowledged and a new byte is waiting, the waiting byte is loaded and sent next.
- R4: On the ninth SCL pulse of each byte the master releases SDA and samples it; low means acknowledge. A high sample sets nack, ends the transfer with a stop and discards any waiting byte, so no further transfer starts.
- R5: ready is 1 after reset and falls in the cycle after a holding-register write. It rises when the waiting byte is loaded into the shifter or discarded.
- R6: After an acknowledged byte with no waiting byte, the master sends a stop (SDA rises while SCL is high) and then sets complete. complete and nack are cleared when the next transfer starts.
- R7: The clock word (address 1) holds the low divider in bits [3:0], the high divider in bits [7:4] and the prescale exponent in bits [9:8]. Every SCL low time is (low+2)<<prescale cycles and every SCL high time inside a transfer is (high+2)<<prescale cycles.
- R8: SDA changes only while SCL is low, except at start and stop. SCL and SDA never change in the same cycle.
- R9: The mode word (address 0) enables the master only when bit 8 (master on) and bit 9 (slave off) are both 1. Otherwise a holding-register write is ignored: the bus stays idle and ready stays 1.
- R10: irq is registered one cycle after the flags and equals the OR of nack, ready and complete, each masked by its enable bit at address 2 (bit 0 nack, bit 1 ready, bit 2 complete).
- R11: After reset both lines are released, ready is 1, and complete, nack and irq are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 mode, 1 clock, 2 interrupt enable, 3 holding |
| wr_data | input | 16 | Register write data |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| ready | output | 1 | Holding register empty |
| complete | output | 1 | Last transfer ended with a stop |
| nack | output | 1 | Last transfer was refused |
| irq | output | 1 | Masked OR of the status flags, registered |

## Verification
ready falls at the first clock edge after a holding-register write. complete and nack clear at the next edge, when the engine leaves idle. An acknowledge decision and its flag updates land at the last edge of the ninth SCL high phase. That decision reads SDA through the two synchronizer flops. irq follows any flag one edge later. The bench drives and samples on the falling clock edge, waits three cycles after launching a transfer before it tests the cleared flags, and polls ready and complete instead of counting bus cycles. It times SCL pulses edge to edge in whole cycles and compares them with the divider formula for each setting of a full sweep over a small range of low and high dividers and prescale values.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;
  localparam logic [1:0] REG_MODE = 2'd0;
  localparam logic [1:0] REG_CLK  = 2'd1;
  localparam logic [1:0] REG_IEN  = 2'd2;
  localparam logic [1:0] REG_HOLD = 2'd3;

  localparam int MODE_ON_BIT   = 8;
  localparam int MODE_SOFF_BIT = 9;

  typedef enum logic [3:0] {
    S_IDLE,
    S_START,
    S_BLO,
    S_BHI,
    S_ALO,
    S_AHI,
    S_PLO,
    S_PHI,
    S_PEND
  } wr_state_e;
endpackage

// File: rtl/i2c_wr_regs.sv
module i2c_wr_regs
  import i2c_wr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 4,
  parameter int PRE_W  = 2,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              go,
  input  logic              take,
  input  logic              drop,
  input  logic              done,
  input  logic              nack_hit,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic              run_ok,
  output logic [DIV_W-1:0]  div_lo,
  output logic [DIV_W-1:0]  div_hi,
  output logic [PRE_W-1:0]  pre,
  output logic              hold_full,
  output logic [7:0]        hold_q,
  output logic              ready,
  output logic              complete,
  output logic              nack,
  output logic              irq
);
  localparam int HI_LSB  = DIV_W;
  localparam int PRE_LSB = 2 * DIV_W;

  logic       m_on, s_off;
  logic [2:0] ien;
  logic       hold_wr;

  assign run_ok  = m_on & s_off;
  assign hold_wr = wr_en && (wr_addr == REG_HOLD) && run_ok;
  assign ready   = ~hold_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_addr <= '0;
      m_on     <= 1'b0;
      s_off    <= 1'b0;
      div_lo   <= '0;
      div_hi   <= '0;
      pre      <= '0;
      ien      <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        REG_MODE: begin
          tgt_addr <= wr_data[ADDR_W-1:0];
          m_on     <= wr_data[MODE_ON_BIT];
          s_off    <= wr_data[MODE_SOFF_BIT];
        end
        REG_CLK: begin
          div_lo <= wr_data[DIV_W-1:0];
          div_hi <= wr_data[HI_LSB +: DIV_W];
          pre    <= wr_data[PRE_LSB +: PRE_W];
        end
        REG_IEN: ien <= wr_data[2:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      complete  <= 1'b0;
      nack      <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (hold_wr) begin
        hold_q    <= wr_data[7:0];
        hold_full <= 1'b1;
      end else if (take || drop) begin
        hold_full <= 1'b0;
      end
      if (go) complete <= 1'b0;
      else if (done) complete <= 1'b1;
      if (go) nack <= 1'b0;
      else if (nack_hit) nack <= 1'b1;
      irq <= |(ien & {complete, ready, nack});
    end
  end
endmodule

// File: rtl/i2c_wr_timer.sv
module i2c_wr_timer #(
  parameter int DIV_W = 4,
  parameter int PRE_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             sel_hi,
  input  logic [DIV_W-1:0] div_lo,
  input  logic [DIV_W-1:0] div_hi,
  input  logic [PRE_W-1:0] pre,
  output logic             expire
);
  localparam int CNT_W = DIV_W + (1 << PRE_W);

  logic [CNT_W-1:0] len, cnt;

  always_comb begin
    len = (CNT_W'(sel_hi ? div_hi : div_lo) + CNT_W'(2)) << pre;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= len - CNT_W'(1);
    else if (cnt != '0) cnt <= cnt - CNT_W'(1);
  end

  assign expire = (cnt == '0);
endmodule

// File: rtl/i2c_wr_engine.sv
module i2c_wr_engine
  import i2c_wr_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_ok,
  input  logic              hold_full,
  input  logic [7:0]        hold_q,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic              expire,
  input  logic              sda_s,
  output logic              go,
  output logic              tmr_load,
  output logic              tmr_hi,
  output logic              take,
  output logic              drop,
  output logic              done,
  output logic              nack_hit,
  output logic              scl_oe,
  output logic              sda_oe
);
  wr_state_e  st, nxt;
  logic [7:0] shreg;
  logic [2:0] bit_idx;
  logic       lag_v, lag_val, bit_nx;

  always_comb begin
    nxt      = st;
    take     = 1'b0;
    drop     = 1'b0;
    done     = 1'b0;
    nack_hit = 1'b0;
    bit_nx   = 1'b1;
    go       = (st == S_IDLE) && hold_full && run_ok;
    case (st)
      S_IDLE:  if (go) nxt = S_START;
      S_START: if (expire) begin nxt = S_BLO; bit_nx = shreg[7]; end
      S_BLO:   if (expire) nxt = S_BHI;
      S_BHI: if (expire) begin
        if (bit_idx == 3'd0) nxt = S_ALO;
        else begin nxt = S_BLO; bit_nx = shreg[6]; end
      end
      S_ALO:   if (expire) nxt = S_AHI;
      S_AHI: if (expire) begin
        if (sda_s) begin
          nack_hit = 1'b1;
          drop     = hold_full;
          nxt      = S_PLO;
        end else if (hold_full) begin
          take   = 1'b1;
          nxt    = S_BLO;
          bit_nx = hold_q[7];
        end else begin
          nxt = S_PLO;
        end
      end
      S_PLO:   if (expire) nxt = S_PHI;
      S_PHI:   if (expire) nxt = S_PEND;
      S_PEND:  if (expire) begin nxt = S_IDLE; done = 1'b1; end
      default: nxt = S_IDLE;
    endcase
    tmr_load = go || ((st != S_IDLE) && expire);
    tmr_hi   = (nxt == S_START) || (nxt == S_BHI) || (nxt == S_AHI) ||
               (nxt == S_PHI) || (nxt == S_PEND);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      shreg   <= '0;
      bit_idx <= '0;
      lag_v   <= 1'b0;
      lag_val <= 1'b0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      st <= nxt;
      if (lag_v) begin
        sda_oe <= lag_val;
        lag_v  <= 1'b0;
      end
      if (go) begin
        shreg   <= {tgt_addr, 1'b0};
        bit_idx <= 3'd7;
        sda_oe  <= 1'b1;
      end else if (tmr_load) begin
        case (nxt)
          S_BLO: begin
            scl_oe  <= 1'b1;
            lag_v   <= 1'b1;
            lag_val <= ~bit_nx;
            if (st == S_BHI) begin
              shreg   <= {shreg[6:0], 1'b0};
              bit_idx <= bit_idx - 3'd1;
            end else if (st == S_AHI) begin
              shreg   <= hold_q;
              bit_idx <= 3'd7;
            end
          end
          S_ALO, S_PLO: begin
            scl_oe  <= 1'b1;
            lag_v   <= 1'b1;
            lag_val <= (nxt == S_PLO);
          end
          S_PEND: begin
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
          end
          default: scl_oe <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_wr_master.sv
module i2c_wr_master
  import i2c_wr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 4,
  parameter int PRE_W  = 2,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              ready,
  output logic              complete,
  output logic              nack,
  output logic              irq
);
  logic [ADDR_W-1:0] tgt_addr;
  logic [DIV_W-1:0]  div_lo, div_hi;
  logic [PRE_W-1:0]  pre;
  logic [7:0]        hold_q;
  logic              run_ok, hold_full;
  logic              go, take, drop, done, nack_hit;
  logic              tmr_load, tmr_hi, expire;
  logic [1:0]        sda_sync;

  always_ff @(posedge clk) begin
    if (rst) sda_sync <= 2'b11;
    else sda_sync <= {sda_sync[0], sda_in};
  end

  i2c_wr_regs #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .go(go), .take(take), .drop(drop), .done(done), .nack_hit(nack_hit),
    .tgt_addr(tgt_addr), .run_ok(run_ok), .div_lo(div_lo), .div_hi(div_hi),
    .pre(pre), .hold_full(hold_full), .hold_q(hold_q), .ready(ready),
    .complete(complete), .nack(nack), .irq(irq)
  );

  i2c_wr_timer #(
    .DIV_W(DIV_W), .PRE_W(PRE_W)
  ) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .sel_hi(tmr_hi),
    .div_lo(div_lo), .div_hi(div_hi), .pre(pre), .expire(expire)
  );

  i2c_wr_engine #(
    .ADDR_W(ADDR_W)
  ) u_engine (
    .clk(clk), .rst(rst), .run_ok(run_ok), .hold_full(hold_full),
    .hold_q(hold_q), .tgt_addr(tgt_addr), .expire(expire), .sda_s(sda_sync[1]),
    .go(go), .tmr_load(tmr_load), .tmr_hi(tmr_hi), .take(take), .drop(drop),
    .done(done), .nack_hit(nack_hit), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );
endmodule

// File: rtl/i2c_wr_master_chk.sv
module i2c_wr_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       ready,
  input logic       complete,
  input logic       nack,
  input logic       irq
);
  // R8
  lines_apart_chk: assert property (@(posedge clk) disable iff (rst)
    !(!$stable(scl_oe) && !$stable(sda_oe)));

  // R6
  done_released_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(complete) |-> (!scl_oe && !sda_oe));

  // R4
  nack_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(nack) |-> scl_oe);

  // R5
  ready_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> $past(wr_en && (wr_addr == 2'd3)));

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(nack) || $past(ready) || $past(complete)));
endmodule

bind i2c_wr_master i2c_wr_master_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .ready(ready),
  .complete(complete), .nack(nack), .irq(irq)
);

// File: tb/i2c_wr_master_tb.sv
`timescale 1ns/1ps
module i2c_wr_master_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        sda_in;
  logic        scl_oe, sda_oe, ready, complete, nack, irq;

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails = 0;

  // bus model state
  bit         pull = 1'b0;
  int         since = 0, starts = 0, stops = 0, werr = 0, bits = 0, nlog = 0;
  int         nack_at = -1, lo_len = 2, hi_len = 2;
  bit         in_xfer = 1'b0, seen_rise = 1'b0;
  logic       scl_prev = 1'b1, sda_prev = 1'b1;
  logic [8:0] cur = '0;
  logic [7:0] log_b [0:15];
  bit         log_a [0:15];

  wire scl_line = ~scl_oe;
  wire sda_line = ~(sda_oe | pull);
  assign sda_in = sda_line;

  i2c_wr_master u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe), .ready(ready),
    .complete(complete), .nack(nack), .irq(irq)
  );

  // Slave and bus monitor; one start and one stop per transfer also shows
  // that SDA never moved while SCL was high at any other time (R8).
  always @(negedge clk) begin
    since++;
    if (scl_line && !scl_prev) begin
      if (in_xfer && since != lo_len) werr++;
      seen_rise = 1'b1;
      since = 0;
      cur = {cur[7:0], sda_line};
      bits++;
      if (bits == 9) begin
        if (nlog < 16) begin
          log_b[nlog] = cur[8:1];
          log_a[nlog] = cur[0];
        end
        nlog++;
        bits = 0;
      end
    end else if (!scl_line && scl_prev) begin
      if (seen_rise && since != hi_len) werr++;
      since = 0;
      pull = (bits == 8) && (nlog != nack_at);
    end else if (scl_line && (sda_line != sda_prev)) begin
      if (!sda_line) begin
        starts++; bits = 0; in_xfer = 1'b1; seen_rise = 1'b0;
      end else begin
        stops++; in_xfer = 1'b0; seen_rise = 1'b0;
      end
    end
    scl_prev = scl_line;
    sda_prev = sda_line;
  end

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_mode(int tgt, bit on, bit soff);
    wr(2'd0, {6'b0, soff, on, 1'b0, 7'(tgt)});
  endtask

  task automatic set_clk(int lo, int hi, int pre);
    wr(2'd1, {6'b0, 2'(pre), 4'(hi), 4'(lo)});
    lo_len = (lo + 2) << pre;
    hi_len = (hi + 2) << pre;
  endtask

  task automatic mon_clear(int nk);
    @(posedge clk);
    starts = 0; stops = 0; werr = 0; nlog = 0; bits = 0; nack_at = nk; pull = 1'b0;
  endtask

  task automatic wait_done();
    int g = 0;
    while (!complete && g < 30000) begin @(negedge clk); g++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic run_xfer(int lo, int hi, int pre, int n, int nk, int tgt, int seed);
    logic [7:0] db [0:7];
    int exp_n, bad;
    set_clk(lo, hi, pre);
    set_mode(tgt, 1'b1, 1'b1);
    for (int i = 0; i < n; i++) db[i] = 8'(seed * 53 + i * 97 + 17);
    mon_clear(nk);
    wr(2'd3, {8'h00, db[0]});
    repeat (3) @(negedge clk);
    chk(!complete && !nack, "R6 flags cleared at start", int'(complete), 0);
    for (int i = 1; i < n; i++) begin
      int guard = 0;
      while (!ready && guard < 5000) begin @(negedge clk); guard++; end
      wr(2'd3, {8'h00, db[i]});
    end
    wait_done();
    exp_n = (nk < 0) ? n + 1 : nk + 1;
    chk(nlog == exp_n, "R3 bytes on bus", nlog, exp_n);
    chk(log_b[0] == {7'(tgt), 1'b0}, "R2 address byte", int'(log_b[0]), int'({7'(tgt), 1'b0}));
    bad = 0;
    for (int i = 1; i < exp_n; i++) if (log_b[i] != db[i-1]) bad++;
    chk(bad == 0, "R3 data byte mismatches", bad, 0);
    bad = 0;
    for (int i = 0; i < exp_n; i++) if (log_a[i] != (i == nk)) bad++;
    chk(bad == 0, "R4 acknowledge bit mismatches", bad, 0);
    chk(starts == 1, "R1 start count", starts, 1);
    chk(stops == 1, "R6 stop count", stops, 1);
    chk(werr == 0, "R7 scl pulse width errors", werr, 0);
    chk(complete == 1'b1, "R6 complete flag", int'(complete), 1);
    chk(nack == (nk >= 0), "R4 nack flag", int'(nack), int'(nk >= 0));
    chk(ready == 1'b1, "R5 ready after transfer", int'(ready), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(!scl_oe && !sda_oe, "R11 lines released", int'({scl_oe, sda_oe}), 0);
    chk(ready == 1'b1, "R11 ready after reset", int'(ready), 1);
    chk(!complete && !nack && !irq, "R11 flags after reset", int'({complete, nack, irq}), 0);

    // R9 master off, then slave not off: holding write ignored
    set_mode(7'h2A, 1'b0, 1'b1);
    mon_clear(-1);
    wr(2'd3, 16'h00A5);
    repeat (200) @(negedge clk);
    chk(starts == 0 && ready, "R9 master off ignores write", starts, 0);
    set_mode(7'h2A, 1'b1, 1'b0);
    wr(2'd3, 16'h005A);
    repeat (200) @(negedge clk);
    chk(starts == 0 && ready && !scl_oe, "R9 slave active ignores write", starts, 0);

    // R7 sweep of dividers and prescale, two data bytes each
    for (int p = 0; p < 3; p++)
      for (int l = 0; l < 4; l++)
        for (int h = 0; h < 4; h++)
          run_xfer(l, h, p, 2, -1, ((p * 16 + l * 4 + h) * 3 + 1) & 8'h7F, p * 16 + l * 4 + h);

    // R3 longer transfer
    run_xfer(1, 2, 1, 5, -1, 7'h55, 99);

    // R10 interrupt masking
    wr(2'd2, 16'h0004);
    repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R10 irq on complete", int'(irq), 1);
    wr(2'd2, 16'h0000);
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R10 irq masked", int'(irq), 0);
    wr(2'd2, 16'h0002);
    repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R10 irq on ready", int'(irq), 1);
    wr(2'd2, 16'h0001);

    // R4 nack on the address byte
    run_xfer(0, 0, 0, 1, 0, 7'h13, 5);
    repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R10 irq on nack", int'(irq), 1);

    // R4 nack on second data byte
    run_xfer(2, 1, 0, 2, 2, 7'h61, 7);

    // R4 waiting byte discarded after nack on first data byte
    set_clk(1, 1, 0);
    mon_clear(1);
    wr(2'd3, 16'h00C3);
    repeat (3) @(negedge clk);
    begin
      int guard = 0;
      while (!ready && guard < 5000) begin @(negedge clk); guard++; end
    end
    wr(2'd3, 16'h003C);
    // R5 ready falls after a holding write
    chk(ready == 1'b0, "R5 ready low with byte waiting", int'(ready), 0);
    wait_done();
    repeat (300) @(negedge clk);
    chk(starts == 1, "R4 no transfer after discard", starts, 1);
    chk(nlog == 2, "R4 bytes before discard", nlog, 2);
    chk(ready == 1'b1 && nack == 1'b1, "R4 discard leaves ready and nack", int'({ready, nack}), 3);

    // R6 nack cleared by the next good transfer
    wr(2'd2, 16'h0000);
    run_xfer(0, 3, 2, 3, -1, 7'h7F, 42);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule